// File: doc/BRIEF.md
# Pixel to Parallel Bus Packer

The packer sits between a pixel stream and a narrow parallel display bus. Pixels arrive on a valid/ready input and leave as bus words on a valid/ready output. A strobe generator downstream turns each word into one bus cycle. Software chooses a pixel size and a bus width, and loads a pixel count. It then pulses `start`. The block works out how many bus cycles each pixel needs, cuts every pixel into words with the most significant bits first, and stops once the programmed number of pixels has been sent.

Four cycle formats exist. One, two or three words per pixel apply when the pixel size is a whole multiple of the bus width. A three-words-per-two-pixels format applies when the pixel is one and a half bus widths wide. In that format a pair of pixels is treated as one continuous bit string, so the middle word carries the tail of the first pixel and the head of the second. A combination that fits none of these formats is refused, and so is an unusable count. The block then stays idle and raises an error flag.

Top module: `pix_bus_packer`

## Requirements
- R1: At an accepted start the format is chosen from the pixel size P and the bus width L, and `out_fmt` shows it: 0 when P=L, 1 when P=2L, 2 when P=3L, 3 when 2P=3L. The select codes are pixel size 12/16/18/24 = 0/1/2/3 and bus width 8/9/12/16 = 0/1/2/3.
- R2: A start whose size pair matches no format sets `cfg_error` and starts no transfer, so `busy`, `in_ready` and `out_valid` stay low. `cfg_error` holds until the next start, and an accepted start clears it.
- R3: In formats 0 to 2, word k of a pixel (k = 0 first) carries pixel bits [P-1-kL : P-L-kL]. The word is right-aligned in `out_word` and the unused upper bits are zero.
- R4: In format 3, pixels A and B form the string {A, B}, which goes out as three L-bit words. Word 1 is A's upper L bits. Word 2 is A's lower L/2 bits above B's upper L/2 bits. Word 3 is B's lower L bits.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_word` hold, and no word is lost or repeated.
- R6: `in_ready` is high only while a transfer runs, not all programmed pixels have been taken, and the next word to send needs a new pixel.
- R7: Exactly the programmed count of pixels is accepted. In the cycle after the last word is handed over, `busy` falls and `frame_done` is high for one cycle.
- R8: A start with a count of zero, or with an odd count in format 3, is refused as in R2.
- R9: While `busy` is high, `start` and changes to the size selects and count have no effect on the transfer or on `out_fmt`.
- R10: After reset `busy`, `in_ready`, `out_valid`, `frame_done` and `cfg_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer, sampled while idle |
| cfg_pix_sel | input | 2 | Pixel size select |
| cfg_bus_sel | input | 2 | Bus width select |
| cfg_count | input | CNT_W | Pixels in the transfer |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted this cycle when valid |
| in_pixel | input | PIX_W | Pixel, right-aligned |
| out_valid | output | 1 | Bus word valid |
| out_ready | input | 1 | Bus side takes the word |
| out_word | output | BUS_W | Bus word, right-aligned |
| out_fmt | output | 2 | Cycle format of the current or last transfer |
| busy | output | 1 | Transfer in progress |
| frame_done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_error | output | 1 | Last start was refused |

## Verification
The assertions rely on a few things about the inputs. Upstream must hold `in_pixel` steady while `in_valid` waits for `in_ready`. Pixel bits above the chosen size must be zero. The design reset must be applied before the first start. The bench drives pixels masked to the selected size and keeps `in_valid` and the pixel fixed until a handshake at a clock edge. Both sides get random stall patterns. The bench covers every pair of size selects, including the refused ones. It builds the expected words by concatenating the pixels' bits and cutting that string into bus-width pieces. This is a different route from the per-format slicing in the RTL.

// File: rtl/pbp_pkg.sv
`timescale 1ns/1ps
package pbp_pkg;

  typedef enum logic [1:0] {
    FMT_1TO1 = 2'd0,
    FMT_2TO1 = 2'd1,
    FMT_3TO1 = 2'd2,
    FMT_3TO2 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic bad;
    fmt_e fmt;
  } fmt_pick_t;

  // pixel size in bits for a select code
  function automatic logic [4:0] pix_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    pix_bits = 5'd12;
      2'd1:    pix_bits = 5'd16;
      2'd2:    pix_bits = 5'd18;
      default: pix_bits = 5'd24;
    endcase
  endfunction

  // bus width in bits for a select code
  function automatic logic [4:0] bus_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    bus_bits = 5'd8;
      2'd1:    bus_bits = 5'd9;
      2'd2:    bus_bits = 5'd12;
      default: bus_bits = 5'd16;
    endcase
  endfunction

  // format from the size ratio; bad flags an unsupported pair
  function automatic fmt_pick_t derive_fmt(input int unsigned p, input int unsigned l);
    fmt_pick_t r;
    r.bad = 1'b0;
    r.fmt = FMT_1TO1;
    if ((p % l) == 0) begin
      case (p / l)
        1:       r.fmt = FMT_1TO1;
        2:       r.fmt = FMT_2TO1;
        3:       r.fmt = FMT_3TO1;
        default: r.bad = 1'b1;
      endcase
    end else if (((2 * p) % l) == 0 && ((2 * p) / l) == 3) begin
      r.fmt = FMT_3TO2;
    end else begin
      r.bad = 1'b1;
    end
    return r;
  endfunction

  // index of the last word in one repeat of the format
  function automatic logic [1:0] last_step(input fmt_e f);
    case (f)
      FMT_1TO1: last_step = 2'd0;
      FMT_2TO1: last_step = 2'd1;
      default:  last_step = 2'd2;
    endcase
  endfunction

  // does word idx need a pixel that has not been fetched yet
  function automatic logic needs_pixel(input fmt_e f, input logic [1:0] idx);
    needs_pixel = (idx == 2'd0) || (f == FMT_3TO2 && idx == 2'd1);
  endfunction

  // word idx of the sequence, from held pixels a (first) and b (second)
  function automatic logic [31:0] word_of(input fmt_e f, input int unsigned p,
                                          input int unsigned l, input logic [1:0] idx,
                                          input logic [31:0] a, input logic [31:0] b);
    logic [31:0] m;
    logic [31:0] hm;
    int unsigned h;
    m  = (32'd1 << l) - 32'd1;
    h  = l / 2;
    hm = (32'd1 << h) - 32'd1;
    if (f == FMT_3TO2) begin
      case (idx)
        2'd0:    word_of = (a >> (p - l)) & m;
        2'd1:    word_of = ((a & hm) << h) | ((b >> (p - h)) & hm);
        default: word_of = b & m;
      endcase
    end else begin
      word_of = (a >> (p - (32'(idx) + 1) * l)) & m;
    end
  endfunction

endpackage

// File: rtl/pbp_fmt_decode.sv
`timescale 1ns/1ps
module pbp_fmt_decode
  import pbp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pix_sel,
  input  logic [1:0]       bus_sel,
  input  logic [CNT_W-1:0] count,
  output fmt_e             fmt,
  output logic [4:0]       pbits,
  output logic [4:0]       lbits,
  output logic             reject
);

  fmt_pick_t pick;
  logic      odd_pairs;
  logic      empty;

  always_comb begin
    pbits     = pix_bits(pix_sel);
    lbits     = bus_bits(bus_sel);
    pick      = derive_fmt(32'(pbits), 32'(lbits));
    fmt       = pick.fmt;
    odd_pairs = (pick.fmt == FMT_3TO2) && count[0];
    empty     = (count == '0);
    reject    = pick.bad || odd_pairs || empty;
  end

  // R1: an accepted format really matches the width ratio
  a_r1_ratio_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pick.bad |-> ((fmt == FMT_3TO2) ? (2 * 32'(pbits) == 3 * 32'(lbits))
                                      : (32'(pbits) == (32'(fmt) + 1) * 32'(lbits))));

endmodule

// File: rtl/pbp_seq.sv
`timescale 1ns/1ps
module pbp_seq
  import pbp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  fmt_e             dec_fmt,
  input  logic [4:0]       dec_pbits,
  input  logic [4:0]       dec_lbits,
  input  logic             dec_reject,
  input  logic [CNT_W-1:0] dec_count,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load_a,
  output logic             load_b,
  output logic [1:0]       idx,
  output fmt_e             fmt_q,
  output logic [4:0]       pbits_q,
  output logic [4:0]       lbits_q,
  output logic             busy,
  output logic             frame_done,
  output logic             cfg_error
);

  logic             full;
  logic [CNT_W-1:0] pix_left;

  // named internal events
  logic       out_fire;
  logic       in_fire;
  logic       at_last;
  logic [1:0] nxt_idx;
  logic       nxt_needs;
  logic [1:0] load_idx;
  logic       finish;
  logic       accept_start;

  always_comb begin
    out_valid    = busy && full;
    out_fire     = out_valid && out_ready;
    at_last      = (idx == last_step(fmt_q));
    nxt_idx      = at_last ? 2'd0 : idx + 2'd1;
    nxt_needs    = needs_pixel(fmt_q, nxt_idx);
    in_ready     = busy && (pix_left != '0) && (!full || (out_fire && nxt_needs));
    in_fire      = in_ready && in_valid;
    load_idx     = full ? nxt_idx : idx;
    load_a       = in_fire && (load_idx == 2'd0);
    load_b       = in_fire && (load_idx == 2'd1);
    finish       = out_fire && nxt_needs && (pix_left == '0);
    accept_start = start && !busy && !dec_reject;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      full       <= 1'b0;
      idx        <= 2'd0;
      pix_left   <= '0;
      fmt_q      <= FMT_1TO1;
      pbits_q    <= 5'd12;
      lbits_q    <= 5'd8;
      frame_done <= 1'b0;
      cfg_error  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!busy) begin
        if (start) begin
          cfg_error <= dec_reject;
          if (!dec_reject) begin
            busy     <= 1'b1;
            full     <= 1'b0;
            idx      <= 2'd0;
            pix_left <= dec_count;
            fmt_q    <= dec_fmt;
            pbits_q  <= dec_pbits;
            lbits_q  <= dec_lbits;
          end
        end
      end else begin
        if (in_fire) pix_left <= pix_left - 1'b1;
        if (finish) begin
          busy       <= 1'b0;
          full       <= 1'b0;
          idx        <= 2'd0;
          frame_done <= 1'b1;
        end else if (out_fire) begin
          idx  <= nxt_idx;
          full <= nxt_needs ? in_fire : 1'b1;
        end else if (!full && in_fire) begin
          full <= 1'b1;
        end
      end
    end
  end

  // R6: pixels are only taken during a transfer
  a_r6_ready_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);
  // R7: frame_done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R7: the transfer only ends with frame_done
  a_r7_end_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> frame_done);
  // R2: a refused start leaves the block idle
  a_r2_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !busy);
  // R9: format latched for the whole transfer
  a_r9_fmt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(fmt_q) && $stable(lbits_q));
  // R8: pixels remain in whole pairs when a 3:2 pair is about to begin
  a_r8_even_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    busy && fmt_q == FMT_3TO2 && idx == 2'd0 && !full |-> !pix_left[0]);
  // R7: a start is never taken over a running transfer
  a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> busy && !cfg_error);

endmodule

// File: rtl/pbp_slicer.sv
`timescale 1ns/1ps
module pbp_slicer
  import pbp_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_a,
  input  logic             load_b,
  input  logic [PIX_W-1:0] in_pixel,
  input  fmt_e             fmt,
  input  logic [4:0]       pbits,
  input  logic [4:0]       lbits,
  input  logic [1:0]       idx,
  output logic [BUS_W-1:0] out_word
);

  logic [PIX_W-1:0] hold_a;
  logic [PIX_W-1:0] hold_b;
  logic [31:0]      word_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      if (load_a) hold_a <= in_pixel;
      if (load_b) hold_b <= in_pixel;
    end
  end

  always_comb begin
    word_full = word_of(fmt, 32'(pbits), 32'(lbits), idx, 32'(hold_a), 32'(hold_b));
    out_word  = word_full[BUS_W-1:0];
  end

  // R3: bits above the bus width are never driven
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_word >> lbits) == '0);

endmodule

// File: rtl/pix_bus_packer.sv
`timescale 1ns/1ps
module pix_bus_packer
  import pbp_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_pix_sel,
  input  logic [1:0]       cfg_bus_sel,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BUS_W-1:0] out_word,
  output logic [1:0]       out_fmt,
  output logic             busy,
  output logic             frame_done,
  output logic             cfg_error
);

  fmt_e       dec_fmt;
  logic [4:0] dec_pbits;
  logic [4:0] dec_lbits;
  logic       dec_reject;
  logic       load_a;
  logic       load_b;
  logic [1:0] idx;
  fmt_e       fmt_q;
  logic [4:0] pbits_q;
  logic [4:0] lbits_q;

  pbp_fmt_decode #(.CNT_W(CNT_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_sel (cfg_pix_sel),
    .bus_sel (cfg_bus_sel),
    .count   (cfg_count),
    .fmt     (dec_fmt),
    .pbits   (dec_pbits),
    .lbits   (dec_lbits),
    .reject  (dec_reject)
  );

  pbp_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dec_fmt    (dec_fmt),
    .dec_pbits  (dec_pbits),
    .dec_lbits  (dec_lbits),
    .dec_reject (dec_reject),
    .dec_count  (cfg_count),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .load_a     (load_a),
    .load_b     (load_b),
    .idx        (idx),
    .fmt_q      (fmt_q),
    .pbits_q    (pbits_q),
    .lbits_q    (lbits_q),
    .busy       (busy),
    .frame_done (frame_done),
    .cfg_error  (cfg_error)
  );

  pbp_slicer #(.PIX_W(PIX_W), .BUS_W(BUS_W)) u_slice (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_a   (load_a),
    .load_b   (load_b),
    .in_pixel (in_pixel),
    .fmt      (fmt_q),
    .pbits    (pbits_q),
    .lbits    (lbits_q),
    .idx      (idx),
    .out_word (out_word)
  );

  assign out_fmt = fmt_q;

  // R5: a stalled word stays put
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));
  // R7: no word is offered once the transfer is over
  a_r7_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !out_valid && !in_ready);

endmodule

// File: tb/tb_pix_bus_packer.sv
`timescale 1ns/1ps
module tb_pix_bus_packer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cfg_pix_sel = '0;
  logic [1:0]  cfg_bus_sel = '0;
  logic [15:0] cfg_count = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_pixel = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_word;
  logic [1:0]  out_fmt;
  logic        busy;
  logic        frame_done;
  logic        cfg_error;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pix_bus_packer dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_pix_sel(cfg_pix_sel), .cfg_bus_sel(cfg_bus_sel), .cfg_count(cfg_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_fmt(out_fmt), .busy(busy), .frame_done(frame_done), .cfg_error(cfg_error)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int psize(input int s);
    int t[4] = '{12, 16, 18, 24};
    return t[s];
  endfunction

  function automatic int lsize(input int s);
    int t[4] = '{8, 9, 12, 16};
    return t[s];
  endfunction

  // expected format by search over multiples; -1 when unsupported
  function automatic int want_fmt(input int p, input int l);
    for (int k = 1; k <= 3; k++) if (k * l == p) return k - 1;
    if (2 * p == 3 * l) return 3;
    return -1;
  endfunction

  task automatic run_xfer(input int ps, input int bs, input int cnt,
                          input int vduty, input int rduty, input bit disturb);
    int p, l, ef, sent, bad_w, hold_bad, ovr, cyc, fmt_bad, nbits;
    bit rej, done, fired_in, prev_stall;
    bit q[$];
    logic [23:0] px [64];
    logic [15:0] w, prev_w;
    p  = psize(ps);
    l  = lsize(bs);
    ef = want_fmt(p, l);
    rej = (ef < 0) || (cnt == 0) || (ef == 3 && (cnt % 2) == 1);
    @(negedge clk);
    cfg_pix_sel = 2'(ps); cfg_bus_sel = 2'(bs); cfg_count = 16'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #5;
    if (rej) begin
      if (ef < 0) check(cfg_error === 1'b1 && busy === 1'b0, "R2 refused pair", int'(cfg_error), 1);
      else        check(cfg_error === 1'b1 && busy === 1'b0, "R8 refused count", int'(cfg_error), 1);
      repeat (3) @(negedge clk);
      #5;
      check(out_valid === 1'b0 && in_ready === 1'b0 && cfg_error === 1'b1,
            "R2 idle after refusal", int'(out_valid) + int'(in_ready), 0);
      return;
    end
    check(busy === 1'b1 && cfg_error === 1'b0, "R7 transfer started", int'(busy), 1);
    check(int'(out_fmt) == ef, "R1 format", int'(out_fmt), ef);
    for (int i = 0; i < cnt; i++) begin
      px[i] = 24'($urandom) & 24'((1 << p) - 1);
      for (int b = p - 1; b >= 0; b--) q.push_back(px[i][b]);
    end
    sent = 0; bad_w = 0; hold_bad = 0; ovr = 0; cyc = 0; fmt_bad = 0;
    done = 0; fired_in = 0; prev_stall = 0; prev_w = '0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (fired_in) begin in_valid = 1'b0; fired_in = 0; end
      start = disturb && (cyc == 3);
      if (disturb && cyc == 3) begin
        cfg_pix_sel = 2'd1; cfg_bus_sel = 2'd0; cfg_count = 16'd1;
      end
      if (!in_valid && sent < cnt && int'($urandom % 100) < vduty) begin
        in_valid = 1'b1; in_pixel = px[sent];
      end
      out_ready = int'($urandom % 100) < rduty;
      #5;
      if (frame_done) done = 1;
      if (busy && int'(out_fmt) != ef) fmt_bad++;
      if (prev_stall && out_word !== prev_w) hold_bad++;
      if (in_ready && sent >= cnt) ovr++;
      if (in_valid && in_ready) begin sent++; fired_in = 1; end
      if (out_valid && out_ready) begin
        w = '0;
        nbits = 0;
        for (int b = 0; b < l; b++) if (q.size() > 0) begin
          w = {w[14:0], q.pop_front()};
          nbits++;
        end
        if (nbits != l || w !== out_word) begin
          bad_w++;
          if (bad_w == 1)
            $display("  word mismatch actual=%h expected=%h", out_word, w);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_w = out_word;
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    check(done, "R7 frame_done seen", int'(done), 1);
    if (ef == 3) check(bad_w == 0, "R4 3:2 packing", bad_w, 0);
    else         check(bad_w == 0, "R3 word order", bad_w, 0);
    check(q.size() == 0 && sent == cnt, "R7 pixel count", sent, cnt);
    check(hold_bad == 0, "R5 stall hold", hold_bad, 0);
    check(ovr == 0, "R6 no extra pixel", ovr, 0);
    check(busy === 1'b0, "R7 busy cleared", int'(busy), 0);
    if (disturb) check(fmt_bad == 0, "R9 busy ignores start and config", fmt_bad, 0);
    @(negedge clk);
    #5;
    check(frame_done === 1'b0, "R7 single pulse", int'(frame_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    check(busy === 1'b0 && in_ready === 1'b0 && out_valid === 1'b0 &&
          frame_done === 1'b0 && cfg_error === 1'b0, "R10 reset state",
          int'(busy) + int'(in_ready) + int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // every size pair, with a mix of stall patterns
    for (int ps = 0; ps < 4; ps++)
      for (int bs = 0; bs < 4; bs++) begin
        run_xfer(ps, bs, 6, 100, 100, 1'b0);
        run_xfer(ps, bs, 10, 60, 40, 1'b0);
      end
    // boundaries: single pixel, single pair
    run_xfer(1, 3, 1, 100, 100, 1'b0);
    run_xfer(0, 0, 2, 50, 50, 1'b0);
    // refused counts, then recovery
    run_xfer(2, 2, 5, 100, 100, 1'b0);
    run_xfer(3, 3, 3, 100, 100, 1'b0);
    run_xfer(1, 0, 0, 100, 100, 1'b0);
    run_xfer(1, 0, 4, 100, 100, 1'b0);
    // start and config changes while busy
    run_xfer(3, 3, 8, 70, 50, 1'b1);
    run_xfer(3, 0, 5, 80, 30, 1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule